// File: doc/BRIEF.md
# Processor Stream Write Port

This block links a processor core's write path to a bank of outgoing 32-bit AXI4-Stream master channels. There are up to sixteen channels. Each request from the core carries a channel index, a data word, a mode flag and an end-of-packet flag. The mode flag chooses between waiting and non-waiting behaviour.

In waiting (blocking) mode, the word is taken at once if the target channel can accept it. If it cannot, a stall line to the core stays high until the channel drains. In non-waiting (non-blocking) mode, the request always finishes within its own cycle. If the channel is occupied, the word is thrown away and a carry flag reports the failure.

Each channel holds one output register. That register is occupied while it presents a beat the consumer has not yet taken. A request index that names no existing channel loads nothing, is treated as a channel that is never occupied, and never stalls.

The controller is a two-state machine:
- **ST_IDLE** is the normal state. It moves to ST_STALL (transition *block_on_busy*) when a blocking request targets an occupied channel.
- **ST_STALL** holds the stall line while the target stays occupied. It returns to ST_IDLE (transition *capture*) in the cycle the channel frees and the word is loaded.
- **ST_IDLE** stays in ST_IDLE (transition *pass*) on every other request and on idle cycles.

Top module: `strm_put_port`

## Requirements
- R1: While reset is held and after it is released, every channel's TVALID is 0, the stall output is 0 and the carry flag is 0.
- R2: A blocking request to a channel that is not occupied raises no stall, and that channel presents the word with TVALID high in the following cycle.
- R3: A blocking request to an occupied channel (TVALID high, TREADY low) holds stall high in every cycle the channel stays occupied. Stall is low in the cycle the channel frees, the word is captured on that edge and appears in the next cycle.
- R4: A non-blocking request never raises the stall output.
- R5: A non-blocking request to an occupied channel leaves that channel's beat untouched and sets carry to 1 from the next cycle.
- R6: A non-blocking request that is accepted clears carry to 0 from the next cycle, and a blocking request leaves carry unchanged.
- R7: A beat's TLAST equals the end-of-packet flag of the request that loaded it (1 marks the last beat of a packet).
- R8: While a channel is occupied, its TDATA and TLAST stay constant and TVALID stays high.
- R9: A channel's register frees on a cycle with TVALID and TREADY both high. A new word may be loaded on that same edge, giving back-to-back beats.
- R10: A request changes no channel other than the one its index selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a write request |
| req_chan | input | CH_W | Target channel index |
| req_data | input | DATA_W | Word to send |
| req_nonblock | input | 1 | 1 = non-blocking request, 0 = blocking |
| req_eop | input | 1 | End-of-packet flag, copied to TLAST |
| stall | output | 1 | Core must hold its request this cycle |
| carry | output | 1 | Last non-blocking request was dropped |
| m_tvalid | output | NUM_CH | Per-channel TVALID |
| m_tdata | output | NUM_CH*DATA_W | Per-channel TDATA, channel k at bits k*DATA_W upward |
| m_tlast | output | NUM_CH | Per-channel TLAST |
| m_tready | input | NUM_CH | Per-channel TREADY from the consumers |

## Verification
The hardest case to reach is a blocking stall that lasts several cycles. It must end exactly when the consumer takes the old beat, and the new word must be captured on that same edge. Other channels must keep shifting during the stall.

The bench drives every consumer's TREADY from a pseudo-random sequence with roughly even odds. It holds the stalled request unchanged for as long as its own model predicts the stall. It sweeps indices, modes and end-of-packet flags over a four-channel configuration. As a result, stalls of varying length, drops by non-blocking requests and back-to-back reloads occur many times. Each of them is compared against the arithmetic model every cycle.

// File: rtl/strm_put_pkg.sv
package strm_put_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_STALL = 1'b1
    } put_state_e;

endpackage

// File: rtl/strm_chan_reg.sv
module strm_chan_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_last,
    input  logic              tready,
    output logic              tvalid,
    output logic [DATA_W-1:0] tdata,
    output logic              tlast,
    output logic              busy
);

    assign busy = tvalid & ~tready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tvalid <= 1'b0;
        end else if (load) begin
            tvalid <= 1'b1;
        end else if (tready) begin
            tvalid <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            tdata <= load_data;
            tlast <= load_last;
        end
    end

    // A held beat must not change until the consumer takes it.
    assert_beat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (tvalid && $stable(tdata) && $stable(tlast)));

    // The controller must never overwrite an occupied register.
    assert_no_clobber_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy);

endmodule

// File: rtl/strm_put_ctrl.sv
module strm_put_ctrl
    import strm_put_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [CH_W-1:0]   req_chan,
    input  logic              req_nonblock,
    input  logic [NUM_CH-1:0] busy_vec,
    output logic [NUM_CH-1:0] load_vec,
    output logic              stall,
    output logic              carry
);

    put_state_e state_q, state_d;
    logic       sel_busy;
    logic       accept;

    always_comb begin
        sel_busy = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (req_chan == CH_W'(i)) sel_busy = busy_vec[i];
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d = state_q;
        stall   = 1'b0;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid && !req_nonblock && sel_busy) begin
                    stall   = 1'b1;
                    state_d = ST_STALL;
                end else if (req_valid && !sel_busy) begin
                    accept = 1'b1;
                end
            end
            ST_STALL: begin
                if (!req_valid) begin
                    state_d = ST_IDLE;
                end else if (sel_busy) begin
                    stall = 1'b1;
                end else begin
                    accept  = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_vec = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (accept && req_chan == CH_W'(i)) load_vec[i] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            carry <= 1'b0;
        end else if (req_valid && req_nonblock) begin
            carry <= sel_busy;
        end
    end

    assert_nb_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonblock) |-> !stall);

    assert_nb_drop_sets_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_nonblock && sel_busy) |=> carry);

    assert_blocking_keeps_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_nonblock) |=> $stable(carry));

    assert_stalled_request_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (req_valid && $stable(req_chan) && !req_nonblock));

    assert_single_target_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_vec));

endmodule

// File: rtl/strm_put_port.sv
module strm_put_port #(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 32,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [CH_W-1:0]          req_chan,
    input  logic [DATA_W-1:0]        req_data,
    input  logic                     req_nonblock,
    input  logic                     req_eop,
    output logic                     stall,
    output logic                     carry,
    output logic [NUM_CH-1:0]        m_tvalid,
    output logic [NUM_CH*DATA_W-1:0] m_tdata,
    output logic [NUM_CH-1:0]        m_tlast,
    input  logic [NUM_CH-1:0]        m_tready
);

    logic [NUM_CH-1:0] busy_vec;
    logic [NUM_CH-1:0] load_vec;

    strm_put_ctrl #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_chan     (req_chan),
        .req_nonblock (req_nonblock),
        .busy_vec     (busy_vec),
        .load_vec     (load_vec),
        .stall        (stall),
        .carry        (carry)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        strm_chan_reg #(
            .DATA_W (DATA_W)
        ) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load_vec[g]),
            .load_data (req_data),
            .load_last (req_eop),
            .tready    (m_tready[g]),
            .tvalid    (m_tvalid[g]),
            .tdata     (m_tdata[g*DATA_W +: DATA_W]),
            .tlast     (m_tlast[g]),
            .busy      (busy_vec[g])
        );
    end

    // A channel that hands over its beat without a reload goes empty (R9).
    assert_free_on_handshake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (m_tvalid[0] && m_tready[0] && !load_vec[0]) |=> !m_tvalid[0]);

endmodule

// File: tb/strm_put_port_tb.sv
module strm_put_port_tb;

    localparam int NCH = 4;
    localparam int DW  = 32;
    localparam int CW  = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            req_valid;
    logic [CW-1:0]   req_chan;
    logic [DW-1:0]   req_data;
    logic            req_nonblock;
    logic            req_eop;
    logic            stall;
    logic            carry;
    logic [NCH-1:0]  m_tvalid;
    logic [NCH*DW-1:0] m_tdata;
    logic [NCH-1:0]  m_tlast;
    logic [NCH-1:0]  m_tready;

    always #4 clk = ~clk;

    strm_put_port #(.NUM_CH(NCH), .DATA_W(DW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_chan     (req_chan),
        .req_data     (req_data),
        .req_nonblock (req_nonblock),
        .req_eop      (req_eop),
        .stall        (stall),
        .carry        (carry),
        .m_tvalid     (m_tvalid),
        .m_tdata      (m_tdata),
        .m_tlast      (m_tlast),
        .m_tready     (m_tready)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic          ev [NCH];
    logic [DW-1:0] ed [NCH];
    logic          el [NCH];
    logic          ec;
    logic [31:0]   seed = 32'h1357_9bdf;

    task automatic chk(input bit ok, input string rq,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] lcg(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog timeout");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic          hold;
        logic          sel_b;
        logic          est;
        logic [CW-1:0] last_chan;

        rst_n = 1'b0; req_valid = 1'b0; req_chan = '0; req_data = '0;
        req_nonblock = 1'b0; req_eop = 1'b0; m_tready = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(m_tvalid == '0, "R1 tvalid", DW'(m_tvalid), '0);
        chk(stall == 1'b0,  "R1 stall",  DW'(stall), '0);
        chk(carry == 1'b0,  "R1 carry",  DW'(carry), '0);
        rst_n = 1'b1;
        for (int k = 0; k < NCH; k++) begin ev[k] = 1'b0; ed[k] = '0; el[k] = 1'b0; end
        ec = 1'b0;
        hold = 1'b0;
        last_chan = '0;

        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            // R6/R5: carry after last request
            chk(carry == ec, "R5/R6 carry", DW'(carry), DW'(ec));
            for (int k = 0; k < NCH; k++) begin
                if (CW'(k) == last_chan)
                    chk(m_tvalid[k] == ev[k], "R2/R9 tvalid", DW'(m_tvalid[k]), DW'(ev[k]));
                else
                    chk(m_tvalid[k] == ev[k], "R10 tvalid", DW'(m_tvalid[k]), DW'(ev[k]));
                if (ev[k]) begin
                    chk(m_tdata[k*DW +: DW] == ed[k], "R8 tdata", m_tdata[k*DW +: DW], ed[k]);
                    chk(m_tlast[k] == el[k], "R7 tlast", DW'(m_tlast[k]), DW'(el[k]));
                end
            end

            seed = lcg(seed);
            if (!hold) begin
                req_valid    = seed[17] | seed[18];
                req_chan     = seed[20:19];
                req_nonblock = seed[21];
                req_eop      = seed[22];
                req_data     = seed ^ 32'(cyc * 7);
            end
            m_tready = seed[27:24];
            #1;
            sel_b = ev[req_chan] & ~m_tready[req_chan];
            est   = req_valid & ~req_nonblock & sel_b;
            if (req_nonblock)
                chk(stall == est, "R4 stall", DW'(stall), DW'(est));
            else
                chk(stall == est, "R3 stall", DW'(stall), DW'(est));

            @(posedge clk);
            for (int k = 0; k < NCH; k++) begin
                if (ev[k] && m_tready[k]) ev[k] = 1'b0;
            end
            if (req_valid && !sel_b) begin
                ev[req_chan] = 1'b1;
                ed[req_chan] = req_data;
                el[req_chan] = req_eop;
            end
            if (req_valid && req_nonblock) ec = sel_b;
            hold = est;
            last_chan = req_chan;
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule